// File: doc/BRIEF.md
# Decode-Stage Operand Bypass and Load Hazard Unit

This block holds the hazard logic of a five-stage integer pipeline. Bypassing is done in the decode stage. The unit looks at the two source register numbers of the instruction in decode. It compares them with the destination registers of the instructions now in execute and memory. From that it chooses, for each of the two ALU operand buses, either a bypassed result or the value read from the register file. Writeback results need no path of their own here. The register file lets a write made in a cycle be seen by a read in the same cycle, so those values already arrive on the register file read data.

A load sitting in execute has no data yet. Its data only becomes available once it reaches the memory stage. If decode needs that register, the unit raises a hold for the PC and the fetch/decode register. In the same cycle it raises a squash request, which puts a no-op with every write enable cleared into execute. On the next cycle the load has moved to memory and its data is bypassed from there. The second operand bus also feeds the data path of a store, so store data is bypassed the same way.

The unit is purely combinational. It sits between the decode register outputs and the decode/execute register.

Top module: `hz_bypass_unit`

## Requirements
- R1: A source register number of 0 yields an operand of zero on its bus (alu_a for the first source, alu_b for the second), whatever the write enables, destinations and register file data are.
- R2: If the execute instruction has its write enable set, is not a load, and its destination equals a nonzero source number, that operand takes ex_result.
- R3: If the memory instruction has its write enable set and its destination equals a nonzero source number, and R2 does not apply, that operand takes mem_result.
- R4: When execute and memory both qualify for the same source, the execute value is chosen.
- R5: A producing stage with its write enable clear is never matched. With no qualifying match, the operand is the register file read data for that source.
- R6: hold_front is 1 exactly when all of the following hold: ex_is_load is 1, ex_wr_en is 1, ex_dst_idx is nonzero, and ex_dst_idx equals a source number whose use flag is 1.
- R7: squash_ex always equals hold_front. A hold and a bubble are always requested together.
- R8: A load in execute is never a bypass source. Its operand falls through to memory-stage or register file data.
- R9: A source whose use flag is 0 never causes a hold. An example is the first source of a shift that takes its amount from an immediate.
- R10: In the cycle after a load-use hold, the load sits in memory with its data on mem_result. hold_front is then 0 and the dependent operand takes mem_result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_rs_idx | input | IDX_W (5) | First source register number of the decode instruction |
| dec_rt_idx | input | IDX_W (5) | Second source register number of the decode instruction |
| dec_rs_used | input | 1 | Decode instruction actually reads its first source |
| dec_rt_used | input | 1 | Decode instruction actually reads its second source |
| rf_rs_data | input | DATA_W (32) | Register file read data for the first source (write-before-read) |
| rf_rt_data | input | DATA_W (32) | Register file read data for the second source |
| ex_dst_idx | input | IDX_W (5) | Destination register of the execute instruction |
| ex_wr_en | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| ex_result | input | DATA_W (32) | ALU result of the execute instruction |
| mem_dst_idx | input | IDX_W (5) | Destination register of the memory instruction |
| mem_wr_en | input | 1 | Memory instruction writes a register |
| mem_result | input | DATA_W (32) | Result of the memory instruction (loaded data for loads) |
| alu_a | output | DATA_W (32) | Selected first operand |
| alu_b | output | DATA_W (32) | Selected second operand, also store data |
| hold_front | output | 1 | Hold the PC and the fetch/decode register this cycle |
| squash_ex | output | 1 | Load a no-op into execute this cycle |

## Verification
The checks assume a few things about the inputs. The values are taken once they have settled. Register numbers lie below the register count. mem_result carries the loaded word whenever a load occupies the memory stage. The bench drives one complete input set per cycle and compares it only after the input edge, well away from it. It builds its pipeline snapshots so that each one is a state a real pipeline could reach. For example, the cycle after a hold shows the load moved from execute into memory, with its data present.

// File: rtl/hz_pkg.sv
package hz_pkg;

    // Number of ALU operand buses served by the unit.
    localparam int unsigned OPND_CNT = 2;

    // Where an operand comes from; the enum order has no meaning.
    typedef enum logic [1:0] {
        SRC_RF   = 2'd0,
        SRC_EX   = 2'd1,
        SRC_MEM  = 2'd2,
        SRC_ZERO = 2'd3
    } opnd_src_e;

    // Priority: register zero, then the younger execute result, then memory.
    function automatic opnd_src_e pick_src(input logic is_zero,
                                           input logic ex_hit,
                                           input logic mem_hit);
        if (is_zero)      return SRC_ZERO;
        else if (ex_hit)  return SRC_EX;
        else if (mem_hit) return SRC_MEM;
        else              return SRC_RF;
    endfunction

endpackage

// File: rtl/hz_operand_mux.sv
module hz_operand_mux #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 5
) (
    input  logic [IDX_W-1:0]  src_idx,
    input  logic [DATA_W-1:0] rf_data,
    input  logic [IDX_W-1:0]  ex_dst,
    input  logic              ex_fwd_ok,
    input  logic [DATA_W-1:0] ex_data,
    input  logic [IDX_W-1:0]  mem_dst,
    input  logic              mem_wr_en,
    input  logic [DATA_W-1:0] mem_data,
    output logic [DATA_W-1:0] opnd
);
    import hz_pkg::*;

    logic      is_zero;
    logic      ex_hit;
    logic      mem_hit;
    opnd_src_e sel;

    assign is_zero = (src_idx == '0);
    assign ex_hit  = ex_fwd_ok && (ex_dst == src_idx);
    assign mem_hit = mem_wr_en && (mem_dst == src_idx);
    assign sel     = pick_src(is_zero, ex_hit, mem_hit);

    always_comb begin
        unique case (sel)
            SRC_ZERO: opnd = '0;
            SRC_EX:   opnd = ex_data;
            SRC_MEM:  opnd = mem_data;
            default:  opnd = rf_data;
        endcase
    end

endmodule

// File: rtl/hz_load_hazard.sv
module hz_load_hazard #(
    parameter int unsigned IDX_W = 5
) (
    input  logic [IDX_W-1:0] rs_idx,
    input  logic [IDX_W-1:0] rt_idx,
    input  logic             rs_used,
    input  logic             rt_used,
    input  logic [IDX_W-1:0] ex_dst,
    input  logic             ex_wr_en,
    input  logic             ex_is_load,
    output logic             stall
);
    logic load_pending;
    logic rs_dep;
    logic rt_dep;

    // A load writing register zero produces nothing anyone waits for.
    assign load_pending = ex_is_load && ex_wr_en && (ex_dst != '0);
    assign rs_dep       = rs_used && (rs_idx == ex_dst);
    assign rt_dep       = rt_used && (rt_idx == ex_dst);
    assign stall        = load_pending && (rs_dep || rt_dep);

endmodule

// File: rtl/hz_bypass_unit.sv
module hz_bypass_unit #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned REG_CNT = 32
) (
    input  logic [$clog2(REG_CNT)-1:0] dec_rs_idx,
    input  logic [$clog2(REG_CNT)-1:0] dec_rt_idx,
    input  logic                       dec_rs_used,
    input  logic                       dec_rt_used,
    input  logic [DATA_W-1:0]          rf_rs_data,
    input  logic [DATA_W-1:0]          rf_rt_data,
    input  logic [$clog2(REG_CNT)-1:0] ex_dst_idx,
    input  logic                       ex_wr_en,
    input  logic                       ex_is_load,
    input  logic [DATA_W-1:0]          ex_result,
    input  logic [$clog2(REG_CNT)-1:0] mem_dst_idx,
    input  logic                       mem_wr_en,
    input  logic [DATA_W-1:0]          mem_result,
    output logic [DATA_W-1:0]          alu_a,
    output logic [DATA_W-1:0]          alu_b,
    output logic                       hold_front,
    output logic                       squash_ex
);
    import hz_pkg::*;

    localparam int unsigned IDX_W = $clog2(REG_CNT);

    logic [IDX_W-1:0]  src_idx [OPND_CNT];
    logic [DATA_W-1:0] rf_data [OPND_CNT];
    logic [DATA_W-1:0] opnd    [OPND_CNT];
    logic              ex_fwd_ok;
    logic              stall;

    assign src_idx[0] = dec_rs_idx;
    assign src_idx[1] = dec_rt_idx;
    assign rf_data[0] = rf_rs_data;
    assign rf_data[1] = rf_rt_data;

    // Load data does not exist yet in execute; only ALU results bypass from there.
    assign ex_fwd_ok = ex_wr_en && !ex_is_load;

    for (genvar k = 0; k < OPND_CNT; k++) begin : g_opnd
        hz_operand_mux #(
            .DATA_W (DATA_W),
            .IDX_W  (IDX_W)
        ) mux_i (
            .src_idx   (src_idx[k]),
            .rf_data   (rf_data[k]),
            .ex_dst    (ex_dst_idx),
            .ex_fwd_ok (ex_fwd_ok),
            .ex_data   (ex_result),
            .mem_dst   (mem_dst_idx),
            .mem_wr_en (mem_wr_en),
            .mem_data  (mem_result),
            .opnd      (opnd[k])
        );
    end

    hz_load_hazard #(
        .IDX_W (IDX_W)
    ) hazard_i (
        .rs_idx     (dec_rs_idx),
        .rt_idx     (dec_rt_idx),
        .rs_used    (dec_rs_used),
        .rt_used    (dec_rt_used),
        .ex_dst     (ex_dst_idx),
        .ex_wr_en   (ex_wr_en),
        .ex_is_load (ex_is_load),
        .stall      (stall)
    );

    assign alu_a      = opnd[0];
    assign alu_b      = opnd[1];
    assign hold_front = stall;
    assign squash_ex  = stall;

endmodule

// File: rtl/hz_bypass_unit_chk.sv
module hz_bypass_unit_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 5
) (
    input logic [IDX_W-1:0]  dec_rs_idx,
    input logic [IDX_W-1:0]  dec_rt_idx,
    input logic              dec_rs_used,
    input logic              dec_rt_used,
    input logic [DATA_W-1:0] rf_rs_data,
    input logic [DATA_W-1:0] rf_rt_data,
    input logic [IDX_W-1:0]  ex_dst_idx,
    input logic              ex_wr_en,
    input logic              ex_is_load,
    input logic [DATA_W-1:0] ex_result,
    input logic [IDX_W-1:0]  mem_dst_idx,
    input logic              mem_wr_en,
    input logic [DATA_W-1:0] mem_result,
    input logic [DATA_W-1:0] alu_a,
    input logic [DATA_W-1:0] alu_b,
    input logic              hold_front,
    input logic              squash_ex
);
    logic a_ex, a_mem, b_ex, b_mem;

    assign a_ex  = ex_wr_en && !ex_is_load && (ex_dst_idx == dec_rs_idx);
    assign a_mem = mem_wr_en && (mem_dst_idx == dec_rs_idx);
    assign b_ex  = ex_wr_en && !ex_is_load && (ex_dst_idx == dec_rt_idx);
    assign b_mem = mem_wr_en && (mem_dst_idx == dec_rt_idx);

    always_comb begin
        p_zero_a_r1: assert (dec_rs_idx != '0 || alu_a == '0)
            else $error("alu_a nonzero for register zero");
        p_zero_b_r1: assert (dec_rt_idx != '0 || alu_b == '0)
            else $error("alu_b nonzero for register zero");
        p_ex_wins_r4: assert (!(dec_rs_idx != '0 && a_ex) || alu_a == ex_result)
            else $error("alu_a did not take the execute result");
        p_mem_src_r3: assert (!(dec_rt_idx != '0 && !b_ex && b_mem) || alu_b == mem_result)
            else $error("alu_b did not take the memory result");
        p_rf_default_r5: assert (!(dec_rs_idx != '0 && !a_ex && !a_mem) || alu_a == rf_rs_data)
            else $error("alu_a did not take register file data");
        p_hold_needs_load_r6: assert (!hold_front || (ex_is_load && ex_wr_en && ex_dst_idx != '0))
            else $error("hold without a writing load in execute");
        p_bubble_pair_r7: assert (squash_ex == hold_front)
            else $error("squash and hold disagree");
        p_unused_quiet_r9: assert (dec_rs_used || dec_rt_used || !hold_front)
            else $error("hold with no source in use");
    end

endmodule

bind hz_bypass_unit hz_bypass_unit_chk #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
) chk_i (.*);

// File: tb/hz_bypass_unit_tb_top.sv
`timescale 1ns/1ps
module hz_bypass_unit_tb_top;

    localparam int unsigned DW = 32;
    localparam int unsigned IW = 5;

    typedef struct {
        string      req;
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        logic       st;
    } exp_t;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [IW-1:0] rs_idx, rt_idx, ex_dst, mem_dst;
    logic          rs_used, rt_used, ex_we, ex_ld, mem_we;
    logic [DW-1:0] rf_a, rf_b, ex_res, mem_res;
    logic [DW-1:0] alu_a, alu_b;
    logic          hold_front, squash_ex;

    hz_bypass_unit dut_i (
        .dec_rs_idx  (rs_idx),
        .dec_rt_idx  (rt_idx),
        .dec_rs_used (rs_used),
        .dec_rt_used (rt_used),
        .rf_rs_data  (rf_a),
        .rf_rt_data  (rf_b),
        .ex_dst_idx  (ex_dst),
        .ex_wr_en    (ex_we),
        .ex_is_load  (ex_ld),
        .ex_result   (ex_res),
        .mem_dst_idx (mem_dst),
        .mem_wr_en   (mem_we),
        .mem_result  (mem_res),
        .alu_a       (alu_a),
        .alu_b       (alu_b),
        .hold_front  (hold_front),
        .squash_ex   (squash_ex)
    );

    exp_t sb_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;

    task automatic check(input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Driver: apply one pipeline snapshot per cycle and queue its expectation.
    task automatic apply(input string req,
                         input logic [IW-1:0] rs, input logic [IW-1:0] rt,
                         input logic rsu, input logic rtu,
                         input logic [DW-1:0] ra, input logic [DW-1:0] rb,
                         input logic [IW-1:0] exd, input logic exw, input logic exl,
                         input logic [DW-1:0] exr,
                         input logic [IW-1:0] md, input logic mw, input logic [DW-1:0] mr,
                         input logic [DW-1:0] ea, input logic [DW-1:0] eb,
                         input logic est);
        exp_t e;
        @(posedge clk);
        #1;
        rs_idx = rs; rt_idx = rt; rs_used = rsu; rt_used = rtu;
        rf_a = ra; rf_b = rb;
        ex_dst = exd; ex_we = exw; ex_ld = exl; ex_res = exr;
        mem_dst = md; mem_we = mw; mem_res = mr;
        e.req = req; e.a = ea; e.b = eb; e.st = est;
        sb_q.push_back(e);
    endtask

    // Monitor: compare at the falling edge, away from input changes.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.req, "alu_a", alu_a, e.a);
                check(e.req, "alu_b", alu_b, e.b);
                check(e.req, "hold_front", {31'd0, hold_front}, {31'd0, e.st});
                check("R7", "squash_ex", {31'd0, squash_ex}, {31'd0, e.st});
            end
        end
    end

    initial begin
        rs_idx = '0; rt_idx = '0; rs_used = 0; rt_used = 0; rf_a = '0; rf_b = '0;
        ex_dst = '0; ex_we = 0; ex_ld = 0; ex_res = '0;
        mem_dst = '0; mem_we = 0; mem_res = '0;
        repeat (2) @(posedge clk);
        // R5 idle pipeline: register file data passes through
        apply("R5", 5'd3, 5'd4, 1, 1, 32'h11, 32'h22, 5'd3, 0, 0, 32'hDEAD, 5'd4, 0, 32'hBEEF,
              32'h11, 32'h22, 0);
        // R2 back-to-back dependent ALU ops on the first source
        apply("R2", 5'd5, 5'd9, 1, 1, 32'h1, 32'h2, 5'd5, 1, 0, 32'hAAAA, 5'd0, 0, 32'h0,
              32'hAAAA, 32'h2, 0);
        // R2 store whose data depends on the previous instruction (second source)
        apply("R2", 5'd1, 5'd6, 1, 1, 32'h7, 32'h8, 5'd6, 1, 0, 32'h6666, 5'd0, 0, 32'h0,
              32'h7, 32'h6666, 0);
        // R3 dependency at distance two
        apply("R3", 5'd5, 5'd12, 1, 1, 32'h1, 32'h2, 5'd9, 1, 0, 32'h9999, 5'd5, 1, 32'h5555,
              32'h5555, 32'h2, 0);
        // R4 execute and memory both hold the register: younger wins
        apply("R4", 5'd7, 5'd7, 1, 1, 32'h1, 32'h2, 5'd7, 1, 0, 32'h7E7E, 5'd7, 1, 32'h7A7A,
              32'h7E7E, 32'h7E7E, 0);
        // R5 matching destinations with write enables clear
        apply("R5", 5'd5, 5'd5, 1, 1, 32'h31, 32'h32, 5'd5, 0, 0, 32'hE0, 5'd5, 0, 32'hE1,
              32'h31, 32'h32, 0);
        // R1 register zero reads zero despite writers and nonzero file data
        apply("R1", 5'd0, 5'd0, 1, 1, 32'h55, 32'h56, 5'd0, 1, 0, 32'hF00D, 5'd0, 1, 32'hCAFE,
              32'h0, 32'h0, 0);
        // R6 load followed directly by a use; R8 load result not bypassed
        apply("R6", 5'd8, 5'd2, 1, 1, 32'h81, 32'h82, 5'd8, 1, 1, 32'h1000, 5'd0, 0, 32'h0,
              32'h81, 32'h82, 1);
        // R10 next cycle: load in memory, data bypassed, hold released
        apply("R10", 5'd8, 5'd2, 1, 1, 32'h81, 32'h82, 5'd0, 0, 0, 32'h0, 5'd8, 1, 32'h4321,
              32'h4321, 32'h82, 0);
        // R9 shift-like: first source unused, load targets it, no hold
        apply("R9", 5'd8, 5'd9, 0, 1, 32'h1, 32'h2, 5'd8, 1, 1, 32'h1000, 5'd0, 0, 32'h0,
              32'h1, 32'h2, 0);
        // R6 load into register zero never holds
        apply("R6", 5'd0, 5'd3, 1, 1, 32'h1, 32'h3, 5'd0, 1, 1, 32'h1000, 5'd0, 0, 32'h0,
              32'h0, 32'h3, 0);
        // R8 load in execute and memory both name reg 10: hold, operand from memory
        apply("R8", 5'd1, 5'd10, 1, 1, 32'h1, 32'hA0, 5'd10, 1, 1, 32'h2000, 5'd10, 1, 32'hA5A5,
              32'h1, 32'hA5A5, 1);
        // R6 load with write enable clear does not hold
        apply("R6", 5'd4, 5'd11, 1, 1, 32'h4, 32'hB, 5'd11, 0, 1, 32'h2000, 5'd0, 0, 32'h0,
              32'h4, 32'hB, 0);
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule